// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block gathers two kinds of requests, six non-maskable trap conditions and a parameterised set of peripheral interrupt sources, and turns them into a single vectored request for a processor core. Each peripheral source keeps a latched flag, an enable bit and a 3-bit programmed level. A source takes part in arbitration only while its flag and its enable are both set. Trap inputs have no enable and sit at fixed levels above every programmable level.

Arbitration runs in two stages. Any asserted trap wins outright, and the lowest trap index wins among traps. When no trap is asserted, the peripheral source with the highest programmed level wins, and a tie goes to the lowest source index. The winner is forwarded only when its level is strictly above the core's current priority input. The output carries the vector number, the level, and the handler address, which is a software-set table base plus four times the vector number. A collapse mode points every peripheral source at one shared vector and leaves the trap vectors unchanged.

Software drives a simple write-only register port. It uses this port to clear flags, set enables and levels, load the table base and select collapse mode.

Top module: `irq_prio_resolver`

## Requirements
- R1: Trap input bit t (0 to 5) is non-maskable. It maps to vector t at level 15 − t, so bit 0 is at level 15 and bit 5 is at level 10. Any asserted trap beats every peripheral source, and the lowest asserted bit wins among traps.
- R2: Peripheral source i has vector 6 + i. It is pending only while its flag and its enable are both 1. A write with wr_addr[7:6]=1 and wr_addr[5:0]=w loads the enables of sources 32w..32w+31 from wr_data bits 0..31. A write with wr_addr[7:6]=2 and wr_addr[5:0]=w loads the 3-bit level of source 8w+k from wr_data[4k+2:4k].
- R3: A high src_event bit sets the source's flag at the clock edge. A write with wr_addr[7:6]=0 and wr_addr[5:0]=w clears the flag of source 32w+j for every set wr_data bit j. In a cycle with both, the clear wins. A source whose event is still held is therefore flagged again one cycle after the clear.
- R4: A request is raised only when the winner's level is strictly greater than cpu_ipl. An equal level raises nothing.
- R5: Among pending peripheral sources the highest level wins. Between equal levels, the lower vector number wins.
- R6: A peripheral source programmed to level 0 never produces a request.
- R7: Writing 1 to bit 0 at address 0xC1 selects collapse mode. In this mode every peripheral winner reports vector 6, and trap vectors are unchanged. Writing 0 restores one vector per source.
- R8: Address 0xC0 loads the table base. irq_addr equals base + 4 × irq_vector.
- R9: The outputs are registered. A change on any input appears on the outputs after the next rising clock edge. Flags and register writes take effect at one edge and appear on the outputs at the following edge. While no request is raised, irq_vector, irq_level and irq_addr are 0.
- R10: A synchronous active-high reset clears all flags, enables, levels, the base and the collapse mode, and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 6 | Trap conditions, bit 0 highest |
| src_event | input | NUM_SRC | Peripheral event strobes that set the flags |
| cpu_ipl | input | 4 | Current core priority, 0 to 15 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address: [7:6] group, [5:0] word |
| wr_data | input | 32 | Register write data |
| irq_valid | output | 1 | Request to the core |
| irq_vector | output | VEC_W | Vector number of the request |
| irq_level | output | 4 | Priority level of the request |
| irq_addr | output | ADDR_W | Handler address, base + 4 × vector |

## Verification
The bound assertions check the following on every cycle. A raised request always sits strictly above the core priority of the previous cycle. A trap vector carries its fixed level. A peripheral winner sits between levels 1 and 7. Collapse mode never reports a peripheral vector above 6. The address always equals the previous cycle's base plus four times the vector. Only the bench scenarios can show the properties that depend on history: which source wins a tie, that a source with a flag but no enable stays silent, the clear-wins ordering with a held event, and the two-edge latency from an event to the output. They check these against a bench model of flags, enables and levels.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_TRAP = 6;
  localparam int LVL_W    = 4;
  localparam int UPRIO_W  = 3;
  localparam logic [LVL_W-1:0] TRAP_TOP_LVL = 4'd15;

  typedef enum logic [1:0] {
    GRP_CLR  = 2'd0,
    GRP_EN   = 2'd1,
    GRP_PRIO = 2'd2,
    GRP_CTRL = 2'd3
  } reg_grp_e;

  localparam logic [5:0] CTRL_BASE = 6'd0;
  localparam logic [5:0] CTRL_MODE = 6'd1;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SRC-1:0]                src_event,
  input  logic                              wr_en,
  input  logic [7:0]                        wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_SRC-1:0][UPRIO_W-1:0]   pend_lvl
);
  localparam int EN_PER_WORD = 32;
  localparam int PR_PER_WORD = 8;

  reg_grp_e   grp;
  logic [5:0] widx;

  assign grp  = reg_grp_e'(wr_addr[7:6]);
  assign widx = wr_addr[5:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int WI = i / EN_PER_WORD;
    localparam int BI = i % EN_PER_WORD;
    localparam int PI = i / PR_PER_WORD;
    localparam int PN = i % PR_PER_WORD;

    logic               flag_q;
    logic               en_q;
    logic [UPRIO_W-1:0] prio_q;
    logic               clr_hit;
    logic               en_hit;
    logic               pr_hit;

    assign clr_hit = wr_en && (grp == GRP_CLR) && (widx == 6'(WI)) && wr_data[BI];
    assign en_hit  = wr_en && (grp == GRP_EN) && (widx == 6'(WI));
    assign pr_hit  = wr_en && (grp == GRP_PRIO) && (widx == 6'(PI));

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
        en_q   <= 1'b0;
        prio_q <= '0;
      end else begin
        if (clr_hit)           flag_q <= 1'b0;
        else if (src_event[i]) flag_q <= 1'b1;
        if (en_hit) en_q   <= wr_data[BI];
        if (pr_hit) prio_q <= wr_data[PN*4 +: UPRIO_W];
      end
    end

    assign pend_lvl[i] = (flag_q && en_q) ? prio_q : '0;
  end
endmodule

// File: rtl/irq_trap_sel.sv
module irq_trap_sel
  import irq_pkg::*;
#(
  parameter int N_TRAP = NUM_TRAP,
  localparam int TIDX_W = (N_TRAP > 1) ? $clog2(N_TRAP) : 1
) (
  input  logic [N_TRAP-1:0] trap_req,
  output logic              found,
  output logic [TIDX_W-1:0] idx,
  output logic [LVL_W-1:0]  level
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int t = N_TRAP - 1; t >= 0; t--) begin
      if (trap_req[t]) begin
        found = 1'b1;
        idx   = TIDX_W'(t);
      end
    end
    level = found ? (TRAP_TOP_LVL - LVL_W'(idx)) : '0;
  end
endmodule

// File: rtl/irq_user_arb.sv
module irq_user_arb
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0][UPRIO_W-1:0] pend_lvl,
  output logic                            found,
  output logic [IDX_W-1:0]                idx,
  output logic [UPRIO_W-1:0]              level
);
  always_comb begin
    level = '0;
    idx   = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if ((pend_lvl[s] != '0) && (pend_lvl[s] >= level)) begin
        level = pend_lvl[s];
        idx   = IDX_W'(s);
      end
    end
    found = (level != '0);
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 32,
  localparam int VEC_W  = $clog2(NUM_TRAP + NUM_SRC),
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int TIDX_W = $clog2(NUM_TRAP)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRAP-1:0] trap_req,
  input  logic [NUM_SRC-1:0]  src_event,
  input  logic [LVL_W-1:0]    cpu_ipl,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [31:0]         wr_data,
  output logic                irq_valid,
  output logic [VEC_W-1:0]    irq_vector,
  output logic [LVL_W-1:0]    irq_level,
  output logic [ADDR_W-1:0]   irq_addr
);
  logic [NUM_SRC-1:0][UPRIO_W-1:0] pend_lvl;
  logic                t_found;
  logic [TIDX_W-1:0]   t_idx;
  logic [LVL_W-1:0]    t_level;
  logic                u_found;
  logic [IDX_W-1:0]    u_idx;
  logic [UPRIO_W-1:0]  u_level;
  logic [ADDR_W-1:0]   base_q;
  logic                collapse_q;
  logic                win_found;
  logic [LVL_W-1:0]    win_level;
  logic [VEC_W-1:0]    win_vec;
  logic                take_req;

  irq_src_bank #(.NUM_SRC(NUM_SRC), .DATA_W(32)) bank_i (
    .clk(clk), .rst(rst), .src_event(src_event), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pend_lvl(pend_lvl)
  );

  irq_trap_sel #(.N_TRAP(NUM_TRAP)) trap_i (
    .trap_req(trap_req), .found(t_found), .idx(t_idx), .level(t_level)
  );

  irq_user_arb #(.NUM_SRC(NUM_SRC)) arb_i (
    .pend_lvl(pend_lvl), .found(u_found), .idx(u_idx), .level(u_level)
  );

  // table base and collapse control
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      collapse_q <= 1'b0;
    end else if (wr_en && (reg_grp_e'(wr_addr[7:6]) == GRP_CTRL)) begin
      if (wr_addr[5:0] == CTRL_BASE) base_q     <= ADDR_W'(wr_data);
      if (wr_addr[5:0] == CTRL_MODE) collapse_q <= wr_data[0];
    end
  end

  // traps first, then programmed peripheral level
  always_comb begin
    win_found = t_found || u_found;
    if (t_found) begin
      win_level = t_level;
      win_vec   = VEC_W'(t_idx);
    end else begin
      win_level = LVL_W'(u_level);
      win_vec   = collapse_q ? VEC_W'(NUM_TRAP) : (VEC_W'(NUM_TRAP) + VEC_W'(u_idx));
    end
    take_req = win_found && (win_level > cpu_ipl);
  end

  always_ff @(posedge clk) begin
    if (rst || !take_req) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
      irq_addr   <= '0;
    end else begin
      irq_valid  <= 1'b1;
      irq_vector <= win_vec;
      irq_level  <= win_level;
      irq_addr   <= base_q + (ADDR_W'(win_vec) << 2);
    end
  end
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 32,
  parameter int VEC_W   = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_TRAP-1:0] trap_req,
  input logic [LVL_W-1:0]    cpu_ipl,
  input logic                irq_valid,
  input logic [VEC_W-1:0]    irq_vector,
  input logic [LVL_W-1:0]    irq_level,
  input logic [ADDR_W-1:0]   irq_addr,
  input logic [ADDR_W-1:0]   base_q,
  input logic                collapse_q
);
  AST_TRAP_FIXED_LVL: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && (irq_vector < VEC_W'(NUM_TRAP))) |-> (irq_level == (TRAP_TOP_LVL - LVL_W'(irq_vector)))); // R1

  AST_TRAP_BEATS_USER: assert property (@(posedge clk) disable iff (rst)
    ((|trap_req) && (cpu_ipl < 4'd10)) |=> (irq_valid && (irq_vector < VEC_W'(NUM_TRAP)))); // R1

  AST_STRICT_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_level > $past(cpu_ipl))); // R4

  AST_USER_LVL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && (irq_vector >= VEC_W'(NUM_TRAP))) |-> ((irq_level != 4'd0) && (irq_level <= 4'd7))); // R6

  AST_COLLAPSED_VEC: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && $past(collapse_q)) |-> (irq_vector <= VEC_W'(NUM_TRAP))); // R7

  AST_ADDR_FROM_BASE: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_addr == ($past(base_q) + (ADDR_W'(irq_vector) << 2)))); // R8
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) chk_i (
  .clk(clk), .rst(rst), .trap_req(trap_req), .cpu_ipl(cpu_ipl),
  .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
  .irq_addr(irq_addr), .base_q(base_q), .collapse_q(collapse_q)
);

// File: tb/irq_prio_resolver_tb_top.sv
module irq_prio_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam int NTRAP = 6;
  localparam int VW = $clog2(NTRAP + NSRC);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [5:0]      trp = '0;
  logic [NSRC-1:0] src_event = '0;
  logic [3:0]      ipl = '0;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic            irq_valid;
  logic [VW-1:0]   irq_vector;
  logic [3:0]      irq_level;
  logic [31:0]     irq_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model of software-visible state
  bit        m_flag [NSRC];
  bit        m_en   [NSRC];
  int        m_prio [NSRC];
  bit [31:0] m_base;
  bit        m_coll;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_resolver #(.NUM_SRC(NSRC), .ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .trap_req(trp), .src_event(src_event), .cpu_ipl(ipl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level), .irq_addr(irq_addr)
  );

  task automatic model_update();
    if (rst) begin
      for (int i = 0; i < NSRC; i++) begin m_flag[i] = 0; m_en[i] = 0; m_prio[i] = 0; end
      m_base = 0; m_coll = 0;
      return;
    end
    for (int i = 0; i < NSRC; i++) begin
      bit clr;
      clr = wr_en && wr_addr[7:6] == 2'd0 && int'(wr_addr[5:0]) == i/32 && wr_data[i%32];
      if (clr) m_flag[i] = 0;
      else if (src_event[i]) m_flag[i] = 1;
      if (wr_en && wr_addr[7:6] == 2'd1 && int'(wr_addr[5:0]) == i/32) m_en[i] = wr_data[i%32];
      if (wr_en && wr_addr[7:6] == 2'd2 && int'(wr_addr[5:0]) == i/8)
        m_prio[i] = int'((wr_data >> (4*(i%8))) & 32'h7);
    end
    if (wr_en && wr_addr == 8'hC0) m_base = wr_data;
    if (wr_en && wr_addr == 8'hC1) m_coll = wr_data[0];
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] ev);
    src_event = ev;
    tick();
    src_event = '0;
    tick();
  endtask

  task automatic check_out(input string tag, input logic ev, input int evec,
                           input int elvl, input logic [31:0] eaddr);
    total++;
    if (irq_valid !== ev || int'(irq_vector) != evec || int'(irq_level) != elvl || irq_addr !== eaddr) begin
      bad++;
      $display("FAIL %s: got valid=%0d vec=%0d lvl=%0d addr=%h, expected valid=%0d vec=%0d lvl=%0d addr=%h",
               tag, irq_valid, irq_vector, irq_level, irq_addr, ev, evec, elvl, eaddr);
    end
  endtask

  task automatic check_model(input string tag);
    bit found = 0;
    int vec = 0, lvl = 0;
    for (int t = NTRAP - 1; t >= 0; t--)
      if (trp[t]) begin found = 1; vec = t; lvl = 15 - t; end
    if (!found) begin
      int best = 0, bi = 0;
      for (int i = NSRC - 1; i >= 0; i--)
        if (m_flag[i] && m_en[i] && m_prio[i] != 0 && m_prio[i] >= best) begin best = m_prio[i]; bi = i; end
      if (best != 0) begin found = 1; lvl = best; vec = m_coll ? NTRAP : NTRAP + bi; end
    end
    if (found && lvl > int'(ipl)) check_out(tag, 1'b1, vec, lvl, m_base + 32'(4*vec));
    else check_out(tag, 1'b0, 0, 0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check_out("R10 reset state", 1'b0, 0, 0, 32'h0);

    // levels: src1=5, src3=5, src4=6 ; enables src3, src4
    do_wr(8'h80, (32'd5 << 4) | (32'd5 << 12) | (32'd6 << 16));
    do_wr(8'h40, 32'h18);
    src_event = 32'h8;
    tick();
    src_event = '0;
    check_out("R9 one edge after event", 1'b0, 0, 0, 32'h0);
    tick();
    check_out("R2 R8 single source", 1'b1, 9, 5, 32'd36);

    // src10 flagged at level 7 but disabled
    do_wr(8'h81, 32'd7 << 8);
    pulse(32'h400);
    check_out("R2 flagged but disabled", 1'b1, 9, 5, 32'd36);

    // tie at level 5: src1 beats src3
    do_wr(8'h40, 32'h1A);
    pulse(32'h2);
    check_out("R5 tie lower vector", 1'b1, 7, 5, 32'd28);

    ipl = 4'd5; tick();
    check_out("R4 equal level blocked", 1'b0, 0, 0, 32'h0);
    ipl = 4'd4; tick();
    check_out("R4 one below", 1'b1, 7, 5, 32'd28);
    ipl = 4'd0;

    // level 0 source never wins
    do_wr(8'h00, 32'h0A);
    do_wr(8'h40, 32'h0010_0000);
    pulse(32'h0010_0000);
    check_out("R6 level zero silent", 1'b0, 0, 0, 32'h0);

    trp = 6'b000100; ipl = 4'd12; tick();
    check_out("R1 address trap", 1'b1, 2, 13, 32'd8);
    ipl = 4'd13; tick();
    check_out("R4 trap at ipl", 1'b0, 0, 0, 32'h0);
    do_wr(8'h82, 32'd7 << 16);
    trp = 6'b111111; ipl = 4'd9; tick();
    check_out("R1 bus error highest", 1'b1, 0, 15, 32'd0);
    trp = 6'b000000; ipl = 4'd0; tick();
    check_out("R5 peripheral after traps", 1'b1, 26, 7, 32'd104);

    do_wr(8'hC1, 32'h1); tick();
    check_out("R7 collapsed vector", 1'b1, 6, 7, 32'd24);
    trp = 6'b010000; tick();
    check_out("R7 trap vector kept", 1'b1, 4, 11, 32'd16);
    trp = '0;
    do_wr(8'hC0, 32'h1000); tick();
    check_out("R8 base collapsed", 1'b1, 6, 7, 32'h1018);
    do_wr(8'hC1, 32'h0); tick();
    check_out("R8 base full table", 1'b1, 26, 7, 32'h1068);

    // persistent source 5
    do_wr(8'hC0, 32'h0);
    do_wr(8'h00, 32'hFFFF_FFFF);
    do_wr(8'h80, 32'd7 << 20);
    do_wr(8'h40, 32'h20);
    src_event = 32'h20;
    tick(); tick();
    check_out("R3 held source", 1'b1, 11, 7, 32'd44);
    do_wr(8'h00, 32'h20);
    tick();
    check_out("R3 clear wins", 1'b0, 0, 0, 32'h0);
    tick();
    check_out("R3 reflagged", 1'b1, 11, 7, 32'd44);
    src_event = '0;
    do_wr(8'h00, 32'h20); tick();
    check_out("R3 cleared stays", 1'b0, 0, 0, 32'h0);

    for (int it = 0; it < 400; it++) begin
      int act;
      act = int'($urandom % 8);
      case (act)
        0: begin wr_en = 1; wr_addr = 8'h40; wr_data = $urandom; end
        1: begin wr_en = 1; wr_addr = 8'h80 | 8'($urandom % 4); wr_data = $urandom & 32'h7777_7777; end
        2: begin wr_en = 1; wr_addr = 8'h00; wr_data = $urandom; end
        3: begin wr_en = 1; wr_addr = 8'hC1; wr_data = $urandom % 2; end
        4: begin wr_en = 1; wr_addr = 8'hC0; wr_data = $urandom & 32'hFFFF_FF00; end
        default: wr_en = 0;
      endcase
      src_event = $urandom & $urandom & $urandom;
      trp = ($urandom % 8 == 0) ? 6'($urandom) : 6'h0;
      ipl = 4'($urandom % 10);
      tick();
      wr_en = 0; src_event = '0;
      tick();
      check_model("R5 R2 random mix");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule